// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block drives the fetch side of a packet transmitter. Packet descriptors sit in system memory as a singly linked chain. Each descriptor holds a status slot, a configuration area, a fragment count and one or more fragment records. The walker reads each descriptor over a word-wide memory port and hands every fragment (a 2-word pointer and a length) to the data mover as a valid/ready stream. It then waits for the MAC to report the end of the packet, writes a completion status word back into the descriptor, and follows the link word to the next descriptor.

Software starts the walk with a one-cycle transmit command and can stop it with a one-cycle halt command. The walk also ends when a link word carries the end-of-list flag, or when the MAC reports an error that calls for an abort. The current-descriptor output always names the last packet worked on, so software can see where the walk stopped. Software can append descriptors and then issue the transmit command again: the walker picks up from the link word of the descriptor it stopped on.

The memory port uses a request/grant handshake. The walker raises `mem_req` with a stable address, write flag and write data until it sees `mem_gnt` in the same cycle. Read data is taken from `mem_rdata` in that grant cycle. The fragment stream follows valid/ready rules: once `frag_valid` is high, the pointer and length stay fixed until `frag_ready` is sampled high. The walker fetches no further memory words while a fragment is waiting.

Top module: `tdl_seq`

## Requirements
- R1: After reset, `busy`, `mem_req` and `frag_valid` are low.
- R2: A descriptor at word address D is laid out as: status at D, configuration at D+1, packet size at D+2, fragment count at D+3 (low 4 bits), and fragment records of three words each starting at D+4 (pointer low word, pointer high word, length). On a start, the walker reads D+1 through D+6 in increasing order. It then presents the first fragment with `frag_addr` = {high word, low word}. A fragment count of 0 is treated as 1.
- R3: For each fragment after the first, the walker reads the next three consecutive words and presents them as one more fragment, until it has presented as many fragments as the count gives.
- R4: While `frag_valid` is high and `frag_ready` is low, `frag_valid`, `frag_addr` and `frag_len` hold their values. No memory request is made between the capture of a fragment and its acceptance.
- R5: When `pkt_done` is seen after the last fragment, the walker writes a status word to D. The status bits are: bit0 completed without abort, bit1 underrun, bit2 byte-count mismatch, bit3 excessive collisions, bit4 excessive deferral; all other bits are zero. The walker then reads the link word, which sits at the word after the last fragment length.
- R6: Link word bit0 is the end-of-list flag, and the word with bit0 cleared is the address of the next descriptor. With the flag set, the walker stops and `cur_desc` keeps D. Otherwise it starts R2 at the new address.
- R7: Underrun, byte-count mismatch or excessive collisions abort the walk. Excessive deferral also aborts when `defer_chk_en` is high; when `defer_chk_en` is low it is only recorded. On an abort, status bit0 is 0, the status word is still written, the link is not read, and `cur_desc` keeps the aborted descriptor.
- R8: A halt command given while busy stops the walk right after the status write of the packet in progress, without reading the link. A halt command given while idle has no effect on a later start.
- R9: A transmit command while busy has no effect on the access sequence.
- R10: A transmit command after any stop first re-reads the link word of the descriptor in `cur_desc`. If the end-of-list flag is still set, the walker stops again after that single read. Otherwise it proceeds to the linked descriptor. The very first start after reset begins at `list_base`.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from the raising of a request until its grant. No request is made while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_cmd | input | 1 | One-cycle transmit command |
| halt_cmd | input | 1 | One-cycle halt command |
| list_base | input | AW | Word address of the first descriptor after reset |
| defer_chk_en | input | 1 | Makes excessive deferral an abort cause |
| pkt_done | input | 1 | One-cycle end-of-packet report from the MAC |
| err_underrun | input | 1 | FIFO underrun, valid with pkt_done |
| err_bytecnt | input | 1 | Byte count mismatch, valid with pkt_done |
| err_coll | input | 1 | Excessive collisions, valid with pkt_done |
| err_defer | input | 1 | Excessive deferral, valid with pkt_done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Grant; the access completes in this cycle |
| mem_rdata | input | DW | Read data, valid in the grant cycle |
| frag_valid | output | 1 | Fragment record is valid |
| frag_ready | input | 1 | Consumer accepts the fragment |
| frag_addr | output | 2*DW | Fragment buffer pointer |
| frag_len | output | DW | Fragment length |
| cur_desc | output | AW | Descriptor in progress, or the last one worked on |
| busy | output | 1 | Walk in progress |

## Verification
Most internal faults in this walker show up quickly at the memory port. An off-by-one pointer or a wrong fragment count makes the next fetch address wrong, and an error there is visible at the first granted access after the fault. A wrong stop decision appears right after the status write: either a link read that should not happen, or a missing one. A lost resume state appears as the wrong first address after the next transmit command. Because of this, the bench compares every granted access (address, direction, data) and every accepted fragment against a sequence it builds from the descriptor contents. It also checks `cur_desc` once each walk has settled.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_FOUT,
    ST_FRAG,
    ST_WAIT,
    ST_STAT,
    ST_LINK
  } tdl_state_e;

  localparam int HDR_WORDS    = 6;
  localparam int FRAG_WORDS   = 3;
  localparam int HDR_CNT_IDX  = 2;
  localparam int HDR_FRAG_IDX = 3;

  localparam int SB_OK    = 0;
  localparam int SB_UNDER = 1;
  localparam int SB_BCM   = 2;
  localparam int SB_COLL  = 3;
  localparam int SB_DEFER = 4;
endpackage

// File: rtl/tdl_err_eval.sv
module tdl_err_eval #(
  parameter int DW = 16
) (
  input  logic          err_underrun,
  input  logic          err_bytecnt,
  input  logic          err_coll,
  input  logic          err_defer,
  input  logic          defer_chk_en,
  output logic          abort,
  output logic [DW-1:0] status
);
  import tdl_pkg::*;

  always_comb begin
    abort = err_underrun | err_bytecnt | err_coll | (err_defer & defer_chk_en);
    status = '0;
    status[SB_OK]    = ~abort;
    status[SB_UNDER] = err_underrun;
    status[SB_BCM]   = err_bytecnt;
    status[SB_COLL]  = err_coll;
    status[SB_DEFER] = err_defer;
  end

  always_comb begin
    a_ok_excl_r7: assert (!(status[SB_OK] && (err_underrun || err_bytecnt || err_coll)))
      else $error("ok bit set with abort cause");
  end
endmodule

// File: rtl/tdl_cmd_ctrl.sv
module tdl_cmd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_cmd,
  input  logic halt_cmd,
  input  logic busy,
  input  logic stop_evt,
  output logic start,
  output logic halt_now
);
  logic halt_pend;

  assign start    = tx_cmd & ~busy;
  assign halt_now = halt_pend | halt_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n)                halt_pend <= 1'b0;
    else if (stop_evt)         halt_pend <= 1'b0;
    else if (halt_cmd && busy) halt_pend <= 1'b1;
  end

  p_halt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !halt_pend)
    else $error("halt request left pending while idle");
endmodule

// File: rtl/tdl_frag_reg.sv
module tdl_frag_reg #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [1:0]      cap_sel,
  input  logic [DW-1:0]   cap_data,
  input  logic            frag_ready,
  output logic            frag_valid,
  output logic [2*DW-1:0] frag_addr,
  output logic [DW-1:0]   frag_len
);
  logic [DW-1:0] lo_q, hi_q, len_q;
  logic          vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      len_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (vld_q && frag_ready) vld_q <= 1'b0;
      if (cap_en) begin
        case (cap_sel)
          2'd0:    lo_q <= cap_data;
          2'd1:    hi_q <= cap_data;
          default: begin
            len_q <= cap_data;
            vld_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign frag_valid = vld_q;
  assign frag_addr  = {hi_q, lo_q};
  assign frag_len   = len_q;

  p_frag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid && !frag_ready |=> frag_valid && $stable(frag_addr) && $stable(frag_len))
    else $error("fragment changed under back-pressure");
endmodule

// File: rtl/tdl_seq.sv
module tdl_seq #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int FCW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_cmd,
  input  logic            halt_cmd,
  input  logic [AW-1:0]   list_base,
  input  logic            defer_chk_en,
  input  logic            pkt_done,
  input  logic            err_underrun,
  input  logic            err_bytecnt,
  input  logic            err_coll,
  input  logic            err_defer,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_gnt,
  input  logic [DW-1:0]   mem_rdata,
  output logic            frag_valid,
  input  logic            frag_ready,
  output logic [2*DW-1:0] frag_addr,
  output logic [DW-1:0]   frag_len,
  output logic [AW-1:0]   cur_desc,
  output logic            busy
);
  import tdl_pkg::*;

  localparam int IDXW = $clog2(HDR_WORDS);
  localparam logic [IDXW-1:0] HDR_LAST  = IDXW'(HDR_WORDS - 1);
  localparam logic [IDXW-1:0] FRAG_LAST = IDXW'(FRAG_WORDS - 1);
  localparam logic [IDXW-1:0] CNT_IDX   = IDXW'(HDR_CNT_IDX);
  localparam logic [IDXW-1:0] FRG_IDX   = IDXW'(HDR_FRAG_IDX);

  tdl_state_e      state;
  logic [AW-1:0]   cur_q, rd_ptr;
  logic [IDXW-1:0] idx;
  logic [FCW-1:0]  frag_left;
  logic [DW-1:0]   stat_q;
  logic            abort_q, have_prev;

  logic            grant, start, halt_now, stop_evt, abort_c;
  logic [DW-1:0]   status_c;
  logic            cap_en;
  logic [1:0]      cap_sel;
  logic [IDXW-1:0] sel_off;
  logic [FCW-1:0]  cnt_field;
  logic [AW-1:0]   link_next;

  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state == ST_HDR) || (state == ST_FRAG) ||
                     (state == ST_STAT) || (state == ST_LINK);
  assign mem_we    = (state == ST_STAT);
  assign mem_addr  = (state == ST_STAT) ? cur_q : rd_ptr;
  assign mem_wdata = stat_q;
  assign cur_desc  = cur_q;
  assign grant     = mem_req && mem_gnt;
  assign cnt_field = mem_rdata[FCW-1:0];
  assign link_next = AW'(mem_rdata) & ~AW'(1);

  assign stop_evt = grant && (((state == ST_STAT) && (abort_q || halt_now)) ||
                              ((state == ST_LINK) && mem_rdata[0]));

  assign cap_en  = grant && (((state == ST_HDR) && (idx >= FRG_IDX)) || (state == ST_FRAG));
  assign sel_off = (state == ST_HDR) ? (idx - FRG_IDX) : idx;
  assign cap_sel = sel_off[1:0];

  tdl_cmd_ctrl u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_cmd   (tx_cmd),
    .halt_cmd (halt_cmd),
    .busy     (busy),
    .stop_evt (stop_evt),
    .start    (start),
    .halt_now (halt_now)
  );

  tdl_err_eval #(.DW(DW)) u_err (
    .err_underrun (err_underrun),
    .err_bytecnt  (err_bytecnt),
    .err_coll     (err_coll),
    .err_defer    (err_defer),
    .defer_chk_en (defer_chk_en),
    .abort        (abort_c),
    .status       (status_c)
  );

  tdl_frag_reg #(.DW(DW)) u_frag (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .cap_sel    (cap_sel),
    .cap_data   (mem_rdata),
    .frag_ready (frag_ready),
    .frag_valid (frag_valid),
    .frag_addr  (frag_addr),
    .frag_len   (frag_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_q     <= '0;
      rd_ptr    <= '0;
      idx       <= '0;
      frag_left <= '0;
      stat_q    <= '0;
      abort_q   <= 1'b0;
      have_prev <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          have_prev <= 1'b1;
          if (have_prev) begin
            state <= ST_LINK;
          end else begin
            cur_q  <= list_base;
            rd_ptr <= list_base + AW'(1);
            idx    <= '0;
            state  <= ST_HDR;
          end
        end
        ST_HDR: if (grant) begin
          rd_ptr <= rd_ptr + AW'(1);
          idx    <= idx + IDXW'(1);
          if (idx == CNT_IDX)
            frag_left <= (cnt_field == '0) ? '0 : cnt_field - FCW'(1);
          if (idx == HDR_LAST) state <= ST_FOUT;
        end
        ST_FOUT: if (frag_valid && frag_ready) begin
          if (frag_left != '0) begin
            frag_left <= frag_left - FCW'(1);
            idx       <= '0;
            state     <= ST_FRAG;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_FRAG: if (grant) begin
          rd_ptr <= rd_ptr + AW'(1);
          idx    <= idx + IDXW'(1);
          if (idx == FRAG_LAST) state <= ST_FOUT;
        end
        ST_WAIT: if (pkt_done) begin
          stat_q  <= status_c;
          abort_q <= abort_c;
          state   <= ST_STAT;
        end
        ST_STAT: if (grant) begin
          state <= (abort_q || halt_now) ? ST_IDLE : ST_LINK;
        end
        ST_LINK: if (grant) begin
          if (mem_rdata[0]) begin
            state <= ST_IDLE;
          end else begin
            cur_q  <= link_next;
            rd_ptr <= link_next + AW'(1);
            idx    <= '0;
            state  <= ST_HDR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))
    else $error("memory request changed before grant");

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req)
    else $error("request while idle");

  p_stat_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr == cur_desc)
    else $error("status write not at descriptor base");

  p_abort_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STAT) && grant && abort_q |=> !busy)
    else $error("walk continued after abort");

  p_eol_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LINK) && grant && mem_rdata[0] |=> !busy && $stable(cur_desc))
    else $error("walk continued past end of list");

  p_no_fetch_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |-> !mem_req)
    else $error("memory fetch while fragment pending");
endmodule

// File: tb/tb_tdl_seq.sv
module tb_tdl_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_cmd = 0, halt_cmd = 0, defer_chk_en = 0, pkt_done = 0;
  logic        err_underrun = 0, err_bytecnt = 0, err_coll = 0, err_defer = 0;
  logic [15:0] list_base = '0;
  logic        mem_req, mem_we, mem_gnt = 0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        frag_valid, frag_ready = 0;
  logic [31:0] frag_addr;
  logic [15:0] frag_len, cur_desc;
  logic        busy;

  logic [15:0] mem [0:255];
  logic [7:0]  lfsr = 8'hA5;
  int          cyc = 0, nchk = 0, nfail = 0;

  logic [15:0] log_addr [0:1023];
  logic        log_we   [0:1023];
  logic [15:0] log_data [0:1023];
  int          log_n = 0;
  logic [31:0] flog_addr [0:511];
  logic [15:0] flog_len  [0:511];
  int          flog_n = 0;

  logic [15:0] exp_addr [0:1023];
  logic        exp_we   [0:1023];
  logic [15:0] exp_data [0:1023];
  int          exp_n = 0;
  logic [31:0] fexp_addr [0:511];
  logic [15:0] fexp_len  [0:511];
  int          fexp_n = 0;

  tdl_seq dut (
    .clk(clk), .rst_n(rst_n), .tx_cmd(tx_cmd), .halt_cmd(halt_cmd),
    .list_base(list_base), .defer_chk_en(defer_chk_en), .pkt_done(pkt_done),
    .err_underrun(err_underrun), .err_bytecnt(err_bytecnt), .err_coll(err_coll),
    .err_defer(err_defer), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_addr(frag_addr),
    .frag_len(frag_len), .cur_desc(cur_desc), .busy(busy)
  );

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(negedge clk) begin
    mem_gnt    = mem_req && (lfsr[0] || lfsr[2]);
    frag_ready = lfsr[1] || lfsr[6];
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_gnt && log_n < 1024) begin
      log_addr[log_n] = mem_addr;
      log_we[log_n]   = mem_we;
      log_data[log_n] = mem_we ? mem_wdata : mem_rdata;
      log_n = log_n + 1;
    end
    if (rst_n && frag_valid && frag_ready && flog_n < 512) begin
      flog_addr[flog_n] = frag_addr;
      flog_len[flog_n]  = frag_len;
      flog_n = flog_n + 1;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: run hung (all requirements) actual=%0d expected<150000", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int a, input bit we, input logic [15:0] d);
    exp_addr[exp_n] = a[15:0];
    exp_we[exp_n]   = we;
    exp_data[exp_n] = d;
    exp_n = exp_n + 1;
  endtask

  task automatic do_reset(input logic [15:0] base);
    @(negedge clk);
    rst_n = 0; tx_cmd = 0; halt_cmd = 0; pkt_done = 0; list_base = base;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic pulse_tx();
    @(negedge clk) tx_cmd = 1;
    @(negedge clk) tx_cmd = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic build(input int d, input int nf, input logic [15:0] link);
    int n;
    n = (nf == 0) ? 1 : nf;
    mem[d]   = 16'h0;
    mem[d+1] = 16'h0C00 + 16'(d);
    mem[d+2] = 16'd64;
    mem[d+3] = 16'(nf);
    for (int i = 0; i < n; i++) begin
      mem[d+4+3*i] = 16'((d << 4) + i);
      mem[d+5+3*i] = 16'h1000 + 16'(i);
      mem[d+6+3*i] = 16'h0040 + 16'(i);
    end
    mem[d+4+3*n] = link;
  endtask

  task automatic run_pkt(input int d, input int nf, input logic [3:0] e,
                         input bit halt_mid, input bit tx_mid, output bit cont);
    int n;
    bit ab;
    logic [15:0] st, lk;
    n = (nf == 0) ? 1 : nf;
    for (int k = 1; k <= 6; k++) push(d + k, 1'b0, mem[d+k]);
    for (int i = 0; i < n; i++) begin
      if (i > 0) for (int k = 0; k < 3; k++) push(d + 4 + 3*i + k, 1'b0, mem[d+4+3*i+k]);
      fexp_addr[fexp_n] = {mem[d+5+3*i], mem[d+4+3*i]};
      fexp_len[fexp_n]  = mem[d+6+3*i];
      fexp_n = fexp_n + 1;
    end
    while (flog_n < fexp_n) @(negedge clk);
    if (halt_mid) begin halt_cmd = 1; @(negedge clk); halt_cmd = 0; end
    if (tx_mid)   begin tx_cmd = 1;   @(negedge clk); tx_cmd = 0;   end
    {err_defer, err_coll, err_bytecnt, err_underrun} = e;
    pkt_done = 1;
    @(negedge clk);
    pkt_done = 0;
    {err_defer, err_coll, err_bytecnt, err_underrun} = 4'h0;
    ab = e[0] | e[1] | e[2] | (e[3] & defer_chk_en);
    st = {11'h0, e, ~ab};
    push(d, 1'b1, st);
    if (ab || halt_mid) cont = 0;
    else begin
      lk = mem[d+4+3*n];
      push(d + 4 + 3*n, 1'b0, lk);
      cont = !lk[0];
    end
  endtask

  task automatic compare(input string tag);
    int m;
    wait_idle();
    chk(log_n == exp_n, {tag, " access count"}, log_n, exp_n);
    m = (log_n < exp_n) ? log_n : exp_n;
    for (int i = 0; i < m; i++) begin
      if (log_addr[i] !== exp_addr[i] || log_we[i] !== exp_we[i] || log_data[i] !== exp_data[i]) begin
        chk(1'b0, {tag, " access"}, {log_we[i], log_addr[i], log_data[i]},
            {exp_we[i], exp_addr[i], exp_data[i]});
      end
    end
    chk(flog_n == fexp_n, {tag, " R4 fragment count"}, flog_n, fexp_n);
    m = (flog_n < fexp_n) ? flog_n : fexp_n;
    for (int i = 0; i < m; i++)
      chk(flog_addr[i] === fexp_addr[i] && flog_len[i] === fexp_len[i],
          {tag, " R4 fragment"}, {flog_addr[i], flog_len[i]}, {fexp_addr[i], fexp_len[i]});
    exp_n = log_n;
    fexp_n = flog_n;
  endtask

  initial begin
    bit c;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;

    // R1: reset state
    do_reset(16'h0010);
    @(negedge clk);
    chk(!busy && !mem_req && !frag_valid, "R1 reset outputs", {busy, mem_req, frag_valid}, 0);

    // R2 R3 R5 R6 R9 R11: chain with fragment counts 0..3
    build(16'h10, 0, 16'h0020);
    build(16'h20, 1, 16'h0030);
    build(16'h30, 2, 16'h0050);
    build(16'h50, 3, 16'h0001);
    pulse_tx();
    run_pkt(16'h10, 0, 4'h0, 0, 0, c);
    run_pkt(16'h20, 1, 4'h0, 0, 1, c);
    run_pkt(16'h30, 2, 4'h0, 0, 0, c);
    run_pkt(16'h50, 3, 4'h0, 0, 0, c);
    compare("R2 R3 R5 R6 R9 R11 chain");
    chk(cur_desc == 16'h50, "R6 cur_desc after end of list", cur_desc, 16'h50);
    chk(!busy, "R6 idle after end of list", busy, 0);

    // R10: resume with end-of-list still set
    pulse_tx();
    push(16'h5D, 1'b0, mem[16'h5D]);
    compare("R10 resume eol kept");
    chk(cur_desc == 16'h50, "R10 cur_desc unchanged", cur_desc, 16'h50);

    // R10: append a descriptor and resume
    build(16'h60, 2, 16'h0061);
    mem[16'h5D] = 16'h0060;
    pulse_tx();
    push(16'h5D, 1'b0, 16'h0060);
    run_pkt(16'h60, 2, 4'h0, 0, 0, c);
    compare("R10 resume appended");
    chk(cur_desc == 16'h60, "R10 cur_desc after append", cur_desc, 16'h60);

    // R8: halt while idle ignored, halt while busy stops after status
    do_reset(16'h0080);
    build(16'h80, 1, 16'h0090);
    build(16'h90, 2, 16'h0091);
    @(negedge clk) halt_cmd = 1;
    @(negedge clk) halt_cmd = 0;
    pulse_tx();
    run_pkt(16'h80, 1, 4'h0, 1, 0, c);
    compare("R8 halt after status");
    chk(cur_desc == 16'h80, "R8 cur_desc after halt", cur_desc, 16'h80);
    pulse_tx();
    push(16'h87, 1'b0, 16'h0090);
    run_pkt(16'h90, 2, 4'h0, 0, 0, c);
    compare("R8 R10 resume after halt");
    chk(cur_desc == 16'h90, "R10 cur_desc after halt resume", cur_desc, 16'h90);

    // R7 R5: sweep all error combinations with and without deferral check
    for (int de = 0; de < 2; de++) begin
      for (int e = 0; e < 16; e++) begin
        defer_chk_en = de[0];
        do_reset(16'h00A0);
        build(16'hA0, 1, 16'h00B0);
        build(16'hB0, 0, 16'h00B1);
        pulse_tx();
        run_pkt(16'hA0, 1, e[3:0], 0, 0, c);
        if (c) run_pkt(16'hB0, 0, 4'h0, 0, 0, c);
        compare("R7 R5 error sweep");
        chk(cur_desc == ((e[2:0] != 0 || (e[3] && de == 1)) ? 16'hA0 : 16'hB0),
            "R7 cur_desc after sweep", cur_desc,
            (e[2:0] != 0 || (e[3] && de == 1)) ? 16'hA0 : 16'hB0);
      end
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule